// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data-memory side of a small 8-bit controller core. A 7-bit file address comes from the instruction and is joined with the bank bit of the status register to form an 8-bit file address. The block turns that address into a read or write of one of three kinds of location: a set of special registers, a 36-byte general-purpose RAM, or nothing at all. Some special registers exist once and are reachable from both banks. Others have a different meaning in each bank. The RAM is mirrored into both banks. The rest of the space is empty.

Offset zero holds no storage of its own. An access there goes through the file-select pointer, and all eight bits of that pointer form the target address. This lets software reach either bank without changing the status bank bit. Registers that serve peripherals are kept here as plain bytes and appear on output ports. The peripherals that use them are outside the block.

Top module: `regfile_bank_decode`

## Requirements
- R1: The file address is {status bit 5, direct address}. With bit 5 clear, offset 01h is the timer byte. With bit 5 set, offset 01h is the option byte.
- R2: Offsets 0Ch–2Fh address 36 RAM bytes that are shared by both banks. A byte written in one bank reads back the same from the other bank.
- R3: File addresses 30h–7Fh and B0h–FFh read 00h, and writes to them change no register.
- R4: Offset 07h in either bank and file address 89h read 00h, and writes to them change no register.
- R5: A direct access to offset 00h reaches the file address held in all 8 bits of the file-select register. The status bank bit plays no part in such an access.
- R6: An indirect access whose pointer is 00h or 80h reads 00h, and a write through it changes no register.
- R7: Offsets 02h (PC low), 03h (status), 04h (file select), 0Ah (PC high latch) and 0Bh (interrupt control) each reach one register from either bank.
- R8: Offsets 01h, 05h, 06h, 08h and 09h are per bank. Bank 0 holds timer, port A data, port B data, NVM data and NVM address. Bank 1 holds option, port A direction, port B direction and NVM control; bank 1 has no register at 09h.
- R9: Read data follows the address combinationally while the read strobe is high, and is 00h while the read strobe is low.
- R10: A write takes effect at the rising clock edge on which the write strobe is high. A synchronous reset sets every register to 00h but leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_addr | input | 7 | Direct file address from the instruction |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| timer_o | output | 8 | Timer byte |
| option_o | output | 8 | Option byte |
| pc_low_o | output | 8 | PC low byte |
| status_o | output | 8 | Status byte; bit 5 is the bank bit |
| fsel_o | output | 8 | File-select pointer |
| pa_data_o | output | 8 | Port A data byte |
| pa_dir_o | output | 8 | Port A direction byte |
| pb_data_o | output | 8 | Port B data byte |
| pb_dir_o | output | 8 | Port B direction byte |
| nvm_data_o | output | 8 | NVM data byte |
| nvm_addr_o | output | 8 | NVM address byte |
| nvm_ctrl_o | output | 8 | NVM control byte |
| pc_high_o | output | 8 | PC high latch byte |
| irq_ctrl_o | output | 8 | Interrupt control byte |

## Verification
An error in the address decode shows up in the same cycle as a wrong rd_data byte, since reads need no clock edge. An error in a stored byte shows up on its output port one edge after the write that caused it. A wrong status bank bit moves every later direct access to the other bank. So the first read of a bank-specific offset after a bank change exposes it. A pointer that is not fully decoded leaves the wrong output port changed after an indirect write, and that can be seen on the next cycle.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    localparam int DW       = 8;
    localparam int AW       = 7;
    localparam int FA_W     = AW + 1;
    localparam int BANK_BIT = 5;
    localparam int GPR_BASE = 12;
    localparam int GPR_CNT  = 36;
    localparam int GPR_LAST = GPR_BASE + GPR_CNT - 1;

    localparam logic [3:0] OFF_TIMER  = 4'h1;
    localparam logic [3:0] OFF_PCL    = 4'h2;
    localparam logic [3:0] OFF_STATUS = 4'h3;
    localparam logic [3:0] OFF_FSEL   = 4'h4;
    localparam logic [3:0] OFF_PA     = 4'h5;
    localparam logic [3:0] OFF_PB     = 4'h6;
    localparam logic [3:0] OFF_GAP    = 4'h7;
    localparam logic [3:0] OFF_NVD    = 4'h8;
    localparam logic [3:0] OFF_NVA    = 4'h9;
    localparam logic [3:0] OFF_PCH    = 4'hA;
    localparam logic [3:0] OFF_IRQ    = 4'hB;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SFR  = 2'd1,
        ACC_GPR  = 2'd2
    } acc_kind_t;

    typedef struct packed {
        logic [DW-1:0] timer;
        logic [DW-1:0] option;
        logic [DW-1:0] pc_low;
        logic [DW-1:0] status;
        logic [DW-1:0] fsel;
        logic [DW-1:0] pa_data;
        logic [DW-1:0] pa_dir;
        logic [DW-1:0] pb_data;
        logic [DW-1:0] pb_dir;
        logic [DW-1:0] nvm_data;
        logic [DW-1:0] nvm_addr;
        logic [DW-1:0] nvm_ctrl;
        logic [DW-1:0] pc_high;
        logic [DW-1:0] irq_ctrl;
    } sfr_regs_t;
endpackage

// File: rtl/rbd_addr_resolve.sv
module rbd_addr_resolve
    import rbd_pkg::*;
(
    input  logic [AW-1:0]   dir_addr,
    input  logic            bank_sel,
    input  logic [FA_W-1:0] fsel,
    output logic [FA_W-1:0] eff_addr,
    output acc_kind_t       kind
);
    localparam logic [AW-1:0] BASE = AW'(GPR_BASE);
    localparam logic [AW-1:0] LAST = AW'(GPR_LAST);

    logic [AW-1:0] off;

    always_comb begin
        if (dir_addr == '0) begin
            eff_addr = fsel;
        end else begin
            eff_addr = {bank_sel, dir_addr};
        end
        off = eff_addr[AW-1:0];

        if (off == '0) begin
            kind = ACC_NONE;
        end else if (off < BASE) begin
            if (off[3:0] == OFF_GAP) begin
                kind = ACC_NONE;
            end else if (eff_addr[AW] && off[3:0] == OFF_NVA) begin
                kind = ACC_NONE;
            end else begin
                kind = ACC_SFR;
            end
        end else if (off <= LAST) begin
            kind = ACC_GPR;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/rbd_sfr_bank.sv
module rbd_sfr_bank
    import rbd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          bank,
    input  logic [3:0]    off,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_val,
    output sfr_regs_t     regs
);
    sfr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            unique case (off)
                OFF_TIMER:  if (bank) regs_d.option = wr_data;
                            else      regs_d.timer  = wr_data;
                OFF_PCL:    regs_d.pc_low = wr_data;
                OFF_STATUS: regs_d.status = wr_data;
                OFF_FSEL:   regs_d.fsel   = wr_data;
                OFF_PA:     if (bank) regs_d.pa_dir  = wr_data;
                            else      regs_d.pa_data = wr_data;
                OFF_PB:     if (bank) regs_d.pb_dir  = wr_data;
                            else      regs_d.pb_data = wr_data;
                OFF_NVD:    if (bank) regs_d.nvm_ctrl = wr_data;
                            else      regs_d.nvm_data = wr_data;
                OFF_NVA:    if (!bank) regs_d.nvm_addr = wr_data;
                OFF_PCH:    regs_d.pc_high  = wr_data;
                OFF_IRQ:    regs_d.irq_ctrl = wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (off)
            OFF_TIMER:  rd_val = bank ? regs_q.option : regs_q.timer;
            OFF_PCL:    rd_val = regs_q.pc_low;
            OFF_STATUS: rd_val = regs_q.status;
            OFF_FSEL:   rd_val = regs_q.fsel;
            OFF_PA:     rd_val = bank ? regs_q.pa_dir : regs_q.pa_data;
            OFF_PB:     rd_val = bank ? regs_q.pb_dir : regs_q.pb_data;
            OFF_NVD:    rd_val = bank ? regs_q.nvm_ctrl : regs_q.nvm_data;
            OFF_NVA:    rd_val = bank ? '0 : regs_q.nvm_addr;
            OFF_PCH:    rd_val = regs_q.pc_high;
            OFF_IRQ:    rd_val = regs_q.irq_ctrl;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/rbd_gpr_ram.sv
module rbd_gpr_ram
    import rbd_pkg::*;
#(
    parameter int DEPTH = GPR_CNT,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wr_data;
        end
    end

    always_comb begin
        if (32'(idx) < DEPTH) begin
            rd_val = mem_q[idx];
        end else begin
            rd_val = '0;
        end
    end
endmodule

// File: rtl/regfile_bank_decode.sv
module regfile_bank_decode
    import rbd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] dir_addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] timer_o,
    output logic [DW-1:0] option_o,
    output logic [DW-1:0] pc_low_o,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] fsel_o,
    output logic [DW-1:0] pa_data_o,
    output logic [DW-1:0] pa_dir_o,
    output logic [DW-1:0] pb_data_o,
    output logic [DW-1:0] pb_dir_o,
    output logic [DW-1:0] nvm_data_o,
    output logic [DW-1:0] nvm_addr_o,
    output logic [DW-1:0] nvm_ctrl_o,
    output logic [DW-1:0] pc_high_o,
    output logic [DW-1:0] irq_ctrl_o
);
    localparam int IW = $clog2(GPR_CNT);
    localparam logic [AW-1:0] BASE = AW'(GPR_BASE);

    sfr_regs_t     regs;
    logic [FA_W-1:0] eff_addr;
    acc_kind_t     acc_kind;
    logic [DW-1:0] sfr_rd, gpr_rd;
    logic [AW-1:0] gpr_rel;
    logic          sfr_we, gpr_we;

    rbd_addr_resolve u_res (
        .dir_addr (dir_addr),
        .bank_sel (regs.status[BANK_BIT]),
        .fsel     (regs.fsel),
        .eff_addr (eff_addr),
        .kind     (acc_kind)
    );

    assign sfr_we  = wr_en && (acc_kind == ACC_SFR);
    assign gpr_we  = wr_en && (acc_kind == ACC_GPR);
    assign gpr_rel = eff_addr[AW-1:0] - BASE;

    rbd_sfr_bank u_sfr (
        .clk     (clk),
        .rst     (rst),
        .we      (sfr_we),
        .bank    (eff_addr[AW]),
        .off     (eff_addr[3:0]),
        .wr_data (wr_data),
        .rd_val  (sfr_rd),
        .regs    (regs)
    );

    rbd_gpr_ram #(.DEPTH(GPR_CNT)) u_gpr (
        .clk     (clk),
        .we      (gpr_we),
        .idx     (gpr_rel[IW-1:0]),
        .wr_data (wr_data),
        .rd_val  (gpr_rd)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (acc_kind)
                ACC_SFR: rd_data = sfr_rd;
                ACC_GPR: rd_data = gpr_rd;
                default: rd_data = '0;
            endcase
        end
    end

    assign timer_o    = regs.timer;
    assign option_o   = regs.option;
    assign pc_low_o   = regs.pc_low;
    assign status_o   = regs.status;
    assign fsel_o     = regs.fsel;
    assign pa_data_o  = regs.pa_data;
    assign pa_dir_o   = regs.pa_dir;
    assign pb_data_o  = regs.pb_data;
    assign pb_dir_o   = regs.pb_dir;
    assign nvm_data_o = regs.nvm_data;
    assign nvm_addr_o = regs.nvm_addr;
    assign nvm_ctrl_o = regs.nvm_ctrl;
    assign pc_high_o  = regs.pc_high;
    assign irq_ctrl_o = regs.irq_ctrl;
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker
    import rbd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   dir_addr,
    input logic            rd_en,
    input logic            wr_en,
    input logic [DW-1:0]   wr_data,
    input logic [DW-1:0]   rd_data,
    input logic [FA_W-1:0] eff_addr,
    input acc_kind_t       acc_kind,
    input logic [DW-1:0]   status_o,
    input logic [DW-1:0]   fsel_o
);
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && acc_kind == ACC_NONE) |-> rd_data == '0);

    assert_empty_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_kind == ACC_NONE) |=> ($stable(status_o) && $stable(fsel_o)));

    assert_fsel_shared_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dir_addr == AW'(4)) |=> fsel_o == $past(wr_data));

    assert_pointer_path_R5: assert property (@(posedge clk) disable iff (rst)
        (dir_addr == '0) |-> eff_addr == fsel_o);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (status_o == '0 && fsel_o == '0));
endmodule

bind regfile_bank_decode rbd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir_addr (dir_addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .eff_addr (eff_addr),
    .acc_kind (acc_kind),
    .status_o (status_o),
    .fsel_o   (fsel_o)
);

// File: tb/sim_regfile_bank_decode.sv
module sim_regfile_bank_decode;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 27;

    // entry: {is_write, addr[6:0], data, expected, tag(3 chars)}
    localparam logic [47:0] VEC [NV] = '{
        {1'b1, 7'h01, 8'hAA, 8'h00, "R8 "},
        {1'b0, 7'h01, 8'h00, 8'hAA, "R8 "},
        {1'b1, 7'h0C, 8'h11, 8'h00, "R2 "},
        {1'b0, 7'h0C, 8'h00, 8'h11, "R2 "},
        {1'b1, 7'h03, 8'h20, 8'h00, "R1 "},
        {1'b0, 7'h01, 8'h00, 8'h00, "R1 "},
        {1'b1, 7'h01, 8'h55, 8'h00, "R1 "},
        {1'b0, 7'h01, 8'h00, 8'h55, "R1 "},
        {1'b0, 7'h0C, 8'h00, 8'h11, "R2 "},
        {1'b1, 7'h2F, 8'h77, 8'h00, "R2 "},
        {1'b0, 7'h03, 8'h00, 8'h20, "R7 "},
        {1'b1, 7'h30, 8'h99, 8'h00, "R3 "},
        {1'b0, 7'h30, 8'h00, 8'h00, "R3 "},
        {1'b0, 7'h7F, 8'h00, 8'h00, "R3 "},
        {1'b0, 7'h07, 8'h00, 8'h00, "R4 "},
        {1'b1, 7'h09, 8'h44, 8'h00, "R4 "},
        {1'b0, 7'h09, 8'h00, 8'h00, "R4 "},
        {1'b1, 7'h08, 8'hC3, 8'h00, "R8 "},
        {1'b1, 7'h0A, 8'h5A, 8'h00, "R7 "},
        {1'b1, 7'h03, 8'h00, 8'h00, "R7 "},
        {1'b0, 7'h0A, 8'h00, 8'h5A, "R7 "},
        {1'b0, 7'h01, 8'h00, 8'hAA, "R1 "},
        {1'b0, 7'h2F, 8'h00, 8'h77, "R2 "},
        {1'b0, 7'h09, 8'h00, 8'h00, "R8 "},
        {1'b0, 7'h08, 8'h00, 8'h00, "R8 "},
        {1'b1, 7'h07, 8'h66, 8'h00, "R4 "},
        {1'b0, 7'h07, 8'h00, 8'h00, "R4 "}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] dir_addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, timer_o, option_o, pc_low_o, status_o, fsel_o;
    logic [7:0] pa_data_o, pa_dir_o, pb_data_o, pb_dir_o;
    logic [7:0] nvm_data_o, nvm_addr_o, nvm_ctrl_o, pc_high_o, irq_ctrl_o;

    int checks = 0;
    int failures = 0;
    logic [47:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_bank_decode u0 (
        .clk(clk), .rst(rst), .dir_addr(dir_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .timer_o(timer_o), .option_o(option_o),
        .pc_low_o(pc_low_o), .status_o(status_o), .fsel_o(fsel_o),
        .pa_data_o(pa_data_o), .pa_dir_o(pa_dir_o), .pb_data_o(pb_data_o),
        .pb_dir_o(pb_dir_o), .nvm_data_o(nvm_data_o), .nvm_addr_o(nvm_addr_o),
        .nvm_ctrl_o(nvm_ctrl_o), .pc_high_o(pc_high_o), .irq_ctrl_o(irq_ctrl_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        dir_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [6:0] a, input logic [7:0] exp);
        @(negedge clk);
        dir_addr = a; rd_en = 1'b1;
        #1;
        check(tag, rd_data, exp);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10", status_o, 8'h00);
        check("R10", fsel_o, 8'h00);
        check("R10", timer_o, 8'h00);
        // R9: no read strobe gives zero
        @(negedge clk);
        dir_addr = 7'h03;
        #1 check("R9", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[47]) wr(v[46:40], v[39:32]);
            else       rd(string'(v[23:0]), v[46:40], v[31:24]);
        end
        check("R8", nvm_ctrl_o, 8'hC3);
        check("R8", nvm_addr_o, 8'h00);
        check("R3", status_o, 8'h00);

        // R9: combinational read follows address
        @(negedge clk);
        rd_en = 1'b1; dir_addr = 7'h0C;
        #1 check("R9", rd_data, 8'h11);
        dir_addr = 7'h2F;
        #1 check("R9", rd_data, 8'h77);
        rd_en = 1'b0;

        // R5: pointer 85h reaches port A direction while bank bit is clear
        wr(7'h04, 8'h85);
        wr(7'h00, 8'h3C);
        check("R5", pa_dir_o, 8'h3C);
        check("R5", pa_data_o, 8'h00);
        rd("R5", 7'h00, 8'h3C);
        rd("R5", 7'h05, 8'h00);
        wr(7'h04, 8'h8C);
        rd("R5", 7'h00, 8'h11);
        wr(7'h04, 8'h89);
        rd("R4", 7'h00, 8'h00);

        // R6: pointer at 80h and 00h
        wr(7'h04, 8'h80);
        wr(7'h00, 8'hFF);
        check("R6", fsel_o, 8'h80);
        check("R6", status_o, 8'h00);
        rd("R6", 7'h00, 8'h00);
        wr(7'h04, 8'h00);
        wr(7'h00, 8'hFF);
        check("R6", fsel_o, 8'h00);
        rd("R6", 7'h00, 8'h00);

        // R3: bank 1 empty space
        wr(7'h03, 8'h20);
        wr(7'h40, 8'hEE);
        rd("R3", 7'h40, 8'h00);
        check("R3", status_o, 8'h20);
        rd("R8", 7'h05, 8'h3C);

        // R10: reset clears registers, RAM kept
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", status_o, 8'h00);
        check("R10", pa_dir_o, 8'h00);
        check("R10", nvm_ctrl_o, 8'h00);
        rd("R10", 7'h0C, 8'h11);
        rd("R10", 7'h01, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule